// File: doc/BRIEF.md
# Stop-Mode Power Controller

This block holds the low-power stop logic of a small microcontroller. A one-cycle `stopReq` pulse stands in for the decoded stop instruction. On that pulse the block makes one fixed change to a 16-bit bank of control and status bits. It clears every core-timer and programmable-timer interrupt flag and enable. It forces the external interrupt enable on and drops the global interrupt mask. The oscillator-select field is left alone. Both oscillator enables then go low, and every internal clock enable is held off.

While stopped, the block watches two kinds of wake source. One is the external interrupt pin, gated by its enable bit. The others are four port interrupt pins, which count only when the port-interrupt option input is set. A wake event pulses `wakeOut` and turns the previously selected oscillator back on. The clock enables stay off for a start-up delay set by `startDelay`, and then the block returns to running. While running, the CPU side writes the whole bank through `cfgWrEn`/`cfgWrData`.

Top module: `stop_power_ctrl`

## Requirements
- R1: After reset the status is running (00), the bank equals 16'h0800, `clkEn` is all ones and only `oscExtEn` is high.
- R2: While running, `cfgWrEn` loads `cfgWrData` into the bank on the next edge, and all six `clkEn` bits are 1. Oscillator select is bank bits 13:12: the value 0 enables only `oscExtEn`, and any nonzero value enables only `oscLpEn`.
- R3: A `stopReq` sampled while running moves the status to stopped (01) on the next edge. While stopped, both oscillator enables are 0, and `clkEn` is 0 in every state other than running. The `clkEn` bits are 0 CPU, 1 watchdog, 2 core timer, 3 programmable timer, 4 analog, 5 serial.
- R4: Stop entry clears bank bits 9:0. These are core-timer overflow flag (0), real-time flag (1), core-timer overflow enable (2), real-time enable (3), input-capture flag (4), output-compare flag (5), timer overflow flag (6), input-capture enable (7), output-compare enable (8) and timer overflow enable (9).
- R5: Stop entry sets bit 10 (external interrupt enable) and clears bit 11 (global interrupt mask).
- R6: Stop entry leaves bits 15:12, including the oscillator-select field, unchanged.
- R7: A `stopReq` takes priority over a write in the same cycle. Writes are ignored in every state except running, and `stopReq` is ignored outside running.
- R8: While stopped, `irqPin` high with bit 10 set moves the status to wake-up (10) on the next edge. `wakeOut` is high for exactly that first wake-up cycle, the selected oscillator is re-enabled, and `clkEn` stays 0.
- R9: The port pins wake the block only when `portIrqOpt` is 1. When `portIrqOpt` is 0 they leave it stopped.
- R10: The wake-up state lasts `startDelay`+1 cycles, with `startDelay` captured at the wake event, and is followed by running with all clocks on.
- R11: Status 2'b11 never occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| stopReq | input | 1 | One-cycle stop request |
| cfgWrEn | input | 1 | Bank write strobe |
| cfgWrData | input | 16 | Bank write data |
| irqPin | input | 1 | External interrupt pin, active high |
| portPins | input | 4 | Port interrupt pins, active high |
| portIrqOpt | input | 1 | Enables port pins as wake sources |
| startDelay | input | 8 | Oscillator start-up delay in cycles |
| ctrlBank | output | 16 | Control and status bank |
| oscExtEn | output | 1 | External-pin oscillator enable |
| oscLpEn | output | 1 | Low-power oscillator enable |
| clkEn | output | 6 | Internal clock enables |
| wakeOut | output | 1 | Wake event pulse |
| pwrState | output | 2 | 00 running, 01 stopped, 10 wake-up |

## Verification
The bench loads banks with every flag and enable set and with spare and select bits set, then checks that stop entry changes only the ten timer bits and the two interrupt bits. A design that masks the wrong field would show a changed oscillator select, or a flag left pending. It drives active port pins with the option off, and a write together with a stop request. A design that gets these wrong would leave stop early, or would lose the stop side effects to the write. It also wakes with delays of 0 and 3 and sends a stop request during wake-up. Off-by-one delay counting shows up as clocks released a cycle early or late, and a leaky state decode shows up as a second stop.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int BANK_W = 16;
  localparam int NUM_CLK = 6;

  // bank layout
  localparam int EXT_IRQ_EN_BIT = 10;
  localparam int INT_MASK_BIT   = 11;
  localparam int OSC_SEL_LO     = 12;
  localparam int OSC_SEL_HI     = 13;

  // stop entry: keep bits 15:12, clear 11 and 9:0, set 10
  localparam logic [BANK_W-1:0] STOP_KEEP = 16'hF000;
  localparam logic [BANK_W-1:0] STOP_SET  = 16'h0400;

  typedef enum logic [1:0] {
    ST_RUN  = 2'b00,
    ST_STOP = 2'b01,
    ST_WAKE = 2'b10
  } pwrState_e;

  typedef struct packed {
    logic applyStop;
    logic wrAllow;
    logic oscOn;
    logic clkOn;
  } ctrlStrobe_t;
endpackage

// File: rtl/spc_ctrl.sv
module spc_ctrl
  import spc_pkg::*;
#(
  parameter int PORT_N = 4,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stopReq,
  input  logic              irqPin,
  input  logic [PORT_N-1:0] portPins,
  input  logic              portIrqOpt,
  input  logic [DLY_W-1:0]  startDelay,
  input  logic              extIrqEn,
  output ctrlStrobe_t       strobe,
  output pwrState_e         state,
  output logic              wakeOut
);
  logic [DLY_W-1:0] dlyCnt;
  logic wakeHit;

  assign wakeHit = (irqPin && extIrqEn) || (portIrqOpt && (|portPins));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_RUN;
      dlyCnt  <= '0;
      wakeOut <= 1'b0;
    end else begin
      wakeOut <= 1'b0;
      case (state)
        ST_RUN: begin
          if (stopReq) state <= ST_STOP;
        end
        ST_STOP: begin
          if (wakeHit) begin
            state   <= ST_WAKE;
            dlyCnt  <= startDelay;
            wakeOut <= 1'b1;
          end
        end
        ST_WAKE: begin
          if (dlyCnt == '0) state <= ST_RUN;
          else dlyCnt <= dlyCnt - 1'b1;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    strobe.applyStop = (state == ST_RUN) && stopReq;
    strobe.wrAllow   = (state == ST_RUN) && !stopReq;
    strobe.oscOn     = (state != ST_STOP);
    strobe.clkOn     = (state == ST_RUN);
  end

  // R8
  wake_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP && wakeHit) |=> (state == ST_WAKE && wakeOut));
  // R9
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP && !wakeHit) |=> (state == ST_STOP && !wakeOut));
  // R10
  wake_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAKE && dlyCnt != '0) |=> (state == ST_WAKE && !wakeOut));
  // R11
  state_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    state != 2'b11);
endmodule

// File: rtl/spc_datapath.sv
module spc_datapath
  import spc_pkg::*;
#(
  parameter logic [BANK_W-1:0] RESET_BANK = 16'h0800
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              wrEn,
  input  logic [BANK_W-1:0] wrData,
  output logic [BANK_W-1:0] bank,
  output logic              oscExtEn,
  output logic              oscLpEn,
  output logic [NUM_CLK-1:0] clkEn
);
  logic extSel;

  always_ff @(posedge clk) begin
    if (!rstN) bank <= RESET_BANK;
    else if (strobe.applyStop) bank <= (bank & STOP_KEEP) | STOP_SET;
    else if (strobe.wrAllow && wrEn) bank <= wrData;
  end

  assign extSel   = (bank[OSC_SEL_HI:OSC_SEL_LO] == 2'b00);
  assign oscExtEn = strobe.oscOn && extSel;
  assign oscLpEn  = strobe.oscOn && !extSel;

  for (genvar g = 0; g < NUM_CLK; g++) begin : gen_gate
    assign clkEn[g] = strobe.clkOn;
  end

  // R4
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.applyStop |=> (bank[9:0] == '0));
  // R5
  stop_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.applyStop |=> (bank[EXT_IRQ_EN_BIT] && !bank[INT_MASK_BIT]));
  // R6
  sel_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.applyStop |=> (bank[15:12] == $past(bank[15:12])));
  // R7
  write_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.wrAllow && !strobe.applyStop) |=> $stable(bank));
  // R3
  osc_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.oscOn |-> (!oscExtEn && !oscLpEn));
  // R2
  osc_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({oscExtEn, oscLpEn}));
endmodule

// File: rtl/stop_power_ctrl.sv
module stop_power_ctrl
  import spc_pkg::*;
#(
  parameter int PORT_N = 4,
  parameter int DLY_W  = 8,
  parameter logic [15:0] RESET_BANK = 16'h0800
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stopReq,
  input  logic              cfgWrEn,
  input  logic [15:0]       cfgWrData,
  input  logic              irqPin,
  input  logic [PORT_N-1:0] portPins,
  input  logic              portIrqOpt,
  input  logic [DLY_W-1:0]  startDelay,
  output logic [15:0]       ctrlBank,
  output logic              oscExtEn,
  output logic              oscLpEn,
  output logic [5:0]        clkEn,
  output logic              wakeOut,
  output logic [1:0]        pwrState
);
  ctrlStrobe_t strobe;
  pwrState_e   state;

  spc_ctrl #(.PORT_N(PORT_N), .DLY_W(DLY_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .irqPin(irqPin),
    .portPins(portPins), .portIrqOpt(portIrqOpt), .startDelay(startDelay),
    .extIrqEn(ctrlBank[EXT_IRQ_EN_BIT]), .strobe(strobe), .state(state),
    .wakeOut(wakeOut)
  );

  spc_datapath #(.RESET_BANK(RESET_BANK)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrEn(cfgWrEn),
    .wrData(cfgWrData), .bank(ctrlBank), .oscExtEn(oscExtEn),
    .oscLpEn(oscLpEn), .clkEn(clkEn)
  );

  assign pwrState = state;

  // R3
  clk_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState != 2'b00) |-> (clkEn == '0));
endmodule

// File: tb/stop_power_ctrl_tb.sv
`timescale 1ns/1ps
module stop_power_ctrl_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopReq = 1'b0, cfgWrEn = 1'b0, irqPin = 1'b0, portIrqOpt = 1'b0;
  logic [15:0] cfgWrData = '0;
  logic [3:0] portPins = '0;
  logic [7:0] startDelay = '0;
  logic [15:0] ctrlBank;
  logic oscExtEn, oscLpEn, wakeOut;
  logic [5:0] clkEn;
  logic [1:0] pwrState;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  stop_power_ctrl dut_i (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .irqPin(irqPin), .portPins(portPins),
    .portIrqOpt(portIrqOpt), .startDelay(startDelay), .ctrlBank(ctrlBank),
    .oscExtEn(oscExtEn), .oscLpEn(oscLpEn), .clkEn(clkEn),
    .wakeOut(wakeOut), .pwrState(pwrState)
  );

  typedef struct {
    logic [1:0]  st;
    logic [15:0] bank;
    logic        ext;
    logic        lp;
    logic [5:0]  ck;
    logic        wk;
    string       tag;
  } exp_t;

  exp_t sbq[$];

  // reference model state
  logic [1:0]  mSt = 2'b00;
  logic [15:0] mBank = 16'h0800;
  logic [7:0]  mCnt = '0;
  logic        mWk = 1'b0;

  task automatic compare(input exp_t e);
    checks++;
    if (pwrState !== e.st || ctrlBank !== e.bank || oscExtEn !== e.ext ||
        oscLpEn !== e.lp || clkEn !== e.ck || wakeOut !== e.wk) begin
      fails++;
      $display("FAIL %s: act st=%b bank=%h ext=%b lp=%b clk=%b wk=%b exp st=%b bank=%h ext=%b lp=%b clk=%b wk=%b",
               e.tag, pwrState, ctrlBank, oscExtEn, oscLpEn, clkEn, wakeOut,
               e.st, e.bank, e.ext, e.lp, e.ck, e.wk);
    end
  endtask

  task automatic step(input string tag, input logic sr, input logic we,
                      input logic [15:0] wd, input logic irq,
                      input logic [3:0] pp, input logic opt, input logic [7:0] dly);
    exp_t e;
    @(negedge clk);
    stopReq = sr; cfgWrEn = we; cfgWrData = wd; irqPin = irq;
    portPins = pp; portIrqOpt = opt; startDelay = dly;
    mWk = 1'b0;
    case (mSt)
      2'b00: begin
        if (sr) begin mBank = (mBank & 16'hF000) | 16'h0400; mSt = 2'b01; end
        else if (we) mBank = wd;
      end
      2'b01: begin
        if ((irq && mBank[10]) || (opt && (|pp))) begin
          mSt = 2'b10; mCnt = dly; mWk = 1'b1;
        end
      end
      default: begin
        if (mCnt == 0) mSt = 2'b00; else mCnt = mCnt - 1;
      end
    endcase
    e.st = mSt; e.bank = mBank; e.wk = mWk; e.tag = tag;
    e.ck = (mSt == 2'b00) ? 6'h3F : 6'h00;
    e.ext = (mSt != 2'b01) && (mBank[13:12] == 2'b00);
    e.lp  = (mSt != 2'b01) && (mBank[13:12] != 2'b00);
    sbq.push_back(e);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 16'h0, 0, 4'h0, 0, 8'h0);
  endtask

  // monitor: pops one expected item per edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) compare(sbq.pop_front());
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: act=timeout exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    exp_t r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    r.st = 2'b00; r.bank = 16'h0800; r.ext = 1; r.lp = 0; r.ck = 6'h3F; r.wk = 0;
    r.tag = "R1";
    compare(r);

    // R2 writes and oscillator select
    step("R2", 0, 1, 16'hB3FF, 0, 4'h0, 0, 8'h0);
    step("R2", 0, 1, 16'h0FFF, 0, 4'h0, 0, 8'h0);
    step("R2", 0, 1, 16'h93FF, 0, 4'h0, 0, 8'h0);
    idle("R2", 1);
    // R3 R4 R5 R6 stop entry
    step("R3_R4_R5_R6", 1, 0, 16'h0, 0, 4'h0, 0, 8'h0);
    // R9 port pins without option
    step("R9", 0, 0, 16'h0, 0, 4'hF, 0, 8'h0);
    step("R9", 0, 0, 16'h0, 0, 4'h2, 0, 8'h0);
    // R7 writes and stop ignored while stopped
    step("R7", 0, 1, 16'h0000, 0, 4'h0, 0, 8'h0);
    step("R7", 1, 0, 16'h0, 0, 4'h0, 0, 8'h0);
    // R8 R10 wake via pin, delay 3
    step("R8", 0, 0, 16'h0, 1, 4'h0, 0, 8'h3);
    step("R10", 1, 1, 16'h1234, 0, 4'h0, 0, 8'h0);
    idle("R10", 5);
    // R7 stop wins over write, select 0 kept
    step("R2", 0, 1, 16'h4CFF, 0, 4'h0, 0, 8'h0);
    step("R7", 1, 1, 16'h0000, 0, 4'h0, 0, 8'h0);
    idle("R3", 2);
    // R9 port wake with option, delay 0
    step("R9", 0, 0, 16'h0, 0, 4'h8, 1, 8'h0);
    idle("R10", 3);
    // R6 spare bits kept, R8 irq wake delay 1
    step("R2", 0, 1, 16'h2BFF, 0, 4'h0, 0, 8'h0);
    step("R6", 1, 0, 16'h0, 0, 4'h0, 0, 8'h0);
    step("R8", 0, 0, 16'h0, 1, 4'h0, 0, 8'h1);
    idle("R10", 4);
    repeat (3) @(posedge clk);
    #1;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule